// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast oscillator-side clock by a programmable ratio of M×N + A, where M is the small modulus of a dual-modulus prescaler, N is a main count and A is a swallow count. It steers the prescaler's modulus-control line. For the first A prescaler periods of every output cycle it asks for a division by M+1, and for the remaining N−A periods it asks for M. Once per complete output cycle it emits a one-clock comparison pulse, which a phase detector downstream compares against a reference.

A digital behavioural model of the dual-modulus prescaler sits inside the block, clocked by the same input clock. This lets the whole loop divider be checked cycle for cycle. A select bit picks the modulus pair from a base value B: the select set to 1 gives B/B+1, and the select cleared gives 2B/2B+1. A low-band build uses B = 16 and a high-band build uses B = 64.

New settings are written through a one-cycle write strobe. They are checked for legality and held back until the current output cycle ends, so no output cycle ever has a length that mixes old and new settings.

Top module: `pswal_divider`

## Requirements
- R1: The number of input clocks from one comparison pulse to the next equals M×N + A. M is BASE_MOD when the select bit is 1 and 2×BASE_MOD when it is 0.
- R2: Within each output cycle, mod_ctrl is high for exactly A×(M+1) input clocks, starting with the first clock of the cycle. With A = 0 it stays low for the whole cycle.
- R3: cmp_pulse is high for exactly one input clock per output cycle.
- R4: A write is legal only when N ≥ 5 and A < N. An illegal write raises cfg_err for exactly the clock after the strobe and leaves the division ratio unchanged. A legal write leaves cfg_err low.
- R5: A legal write takes effect at the next output-cycle boundary. The output cycle in progress when the write arrives keeps its full old length.
- R6: When several writes arrive within one output cycle, the last legal one is applied at the boundary. An illegal write that follows a legal one does not cancel it.
- R7: After reset, cmp_pulse, cfg_err and mod_ctrl are low, and the divider runs with N = DEF_N, A = 0 and select = 1, which gives a period of BASE_MOD×DEF_N clocks.
- R8: The extreme legal settings divide correctly: N = 5 with A = 4, and N = 2047 with A = 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-side input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | One-cycle strobe that offers new settings |
| cfg_n | input | N_W (11) | Main count N |
| cfg_a | input | A_W (7) | Swallow count A |
| cfg_sw | input | 1 | Modulus select: 1 gives BASE_MOD, 0 gives 2×BASE_MOD |
| mod_ctrl | output | 1 | Modulus request to the prescaler; high asks for M+1 |
| cmp_pulse | output | 1 | One-clock comparison pulse, once per output cycle |
| cfg_err | output | 1 | One-clock flag after an illegal write |

## Verification
The bench builds the divider with BASE_MOD = 4, so the modulus pairs are 4/5 and 8/9. The counter widths stay at their full default of 11 and 7 bits. The small base keeps even the largest legal ratio, 8×2047+127 = 16503 clocks, short enough to measure several whole periods at N = 2047 and A = 127. It also makes the minimum case, N = 5 with A = 4, only 24 clocks long. With this build, periods, modulus-control duty, boundary-aligned updates and last-write-wins ordering can all be checked at both ends of the legal range.

// File: rtl/pswal_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the pulse-swallow divider.
// Assumes the main count is never narrower than the swallow count.
package pswal_pkg;

    localparam int unsigned PS_N_BITS = 11;  // main counter width
    localparam int unsigned PS_A_BITS = 7;   // swallow counter width
    localparam int unsigned PS_MIN_N  = 5;   // smallest legal main count

    // Modulus M chosen by the select bit from the base modulus.
    function automatic int unsigned pick_mod(input logic sw, input int unsigned base);
        return sw ? base : 2 * base;
    endfunction

endpackage

// File: rtl/pswal_cfg.sv
`timescale 1ns/1ps
// Module: pswal_cfg
// Checks incoming settings, holds a legal pending set and swaps it into the
// active set only at an output-cycle boundary. It exports the settings that
// apply from the next clock on (active, or pending at a boundary).
// Assumes N_W >= A_W.
module pswal_cfg
    import pswal_pkg::*;
#(
    parameter int unsigned N_W   = PS_N_BITS,
    parameter int unsigned A_W   = PS_A_BITS,
    parameter int unsigned DEF_N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [N_W-1:0] n_i,
    input  logic [A_W-1:0] a_i,
    input  logic           sw_i,
    input  logic           bnd_i,
    output logic [N_W-1:0] n_nx_o,
    output logic [A_W-1:0] a_nx_o,
    output logic           sw_nx_o,
    output logic           err_o
);

    logic [N_W-1:0] pend_n, act_n;
    logic [A_W-1:0] pend_a, act_a;
    logic           pend_sw, act_sw, pend_v;
    logic           legal, take, err_q;

    // Legality of the offered settings: N large enough, swallow below main.
    always_comb begin
        legal = (n_i >= N_W'(PS_MIN_N)) && (N_W'(a_i) < n_i);
    end

    // Pending capture, boundary swap and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_n  <= N_W'(DEF_N);
            pend_a  <= '0;
            pend_sw <= 1'b1;
            pend_v  <= 1'b0;
            act_n   <= N_W'(DEF_N);
            act_a   <= '0;
            act_sw  <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            err_q <= wr_i && !legal;
            if (wr_i && legal) begin
                pend_n  <= n_i;
                pend_a  <= a_i;
                pend_sw <= sw_i;
                pend_v  <= 1'b1;
            end else if (bnd_i) begin
                pend_v  <= 1'b0;
            end
            if (take) begin
                act_n  <= pend_n;
                act_a  <= pend_a;
                act_sw <= pend_sw;
            end
        end
    end

    // Settings in force from the next clock.
    always_comb begin
        take    = bnd_i && pend_v;
        n_nx_o  = take ? pend_n  : act_n;
        a_nx_o  = take ? pend_a  : act_a;
        sw_nx_o = take ? pend_sw : act_sw;
        err_o   = err_q;
    end

    // The active set only ever holds legal settings.
    p_active_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_n >= N_W'(PS_MIN_N)) && (N_W'(act_a) < act_n));

    // Active settings change only across a boundary.
    p_hold_midcycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_i |=> ($stable(act_n) && $stable(act_a) && $stable(act_sw)));

endmodule

// File: rtl/pswal_prescaler.sv
`timescale 1ns/1ps
// Module: pswal_prescaler
// Behavioural dual-modulus prescaler model. It emits a one-clock tick at
// the end of each prescaler period and, on that tick, picks the length of
// the next period: M+1 when plus_i is high, M otherwise, with M set by sw_i.
// Assumes BASE >= 2, so ticks are never adjacent.
module pswal_prescaler
    import pswal_pkg::*;
#(
    parameter int unsigned BASE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_i,
    input  logic plus_i,
    output logic tick_o
);

    localparam int unsigned TOP  = 2 * BASE;
    localparam int unsigned PC_W = $clog2(TOP + 1);

    logic [PC_W-1:0] pc_q, reload;
    int unsigned     m_sel;

    // Length of the next prescaler period, minus one.
    always_comb begin
        m_sel  = pick_mod(sw_i, BASE);
        reload = plus_i ? PC_W'(m_sel) : PC_W'(m_sel - 1);
        tick_o = (pc_q == '0);
    end

    // Down-counter that reloads on its terminal tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= PC_W'(BASE - 1);
        end else if (tick_o) begin
            pc_q <= reload;
        end else begin
            pc_q <= pc_q - PC_W'(1);
        end
    end

    // Period never exceeds the larger modulus plus one.
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= PC_W'(TOP));

    // Consecutive ticks are impossible with a modulus of two or more.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/pswal_counters.sv
`timescale 1ns/1ps
// Module: pswal_counters
// Main and swallow counters advanced once per prescaler tick. The main
// counter marks the output-cycle boundary on its last tick, where both
// counters reload from the settings in force next. The swallow counter
// requests M+1 while it is non-zero.
// Assumes the loaded swallow count is below the loaded main count.
module pswal_counters #(
    parameter int unsigned N_W   = 11,
    parameter int unsigned A_W   = 7,
    parameter int unsigned DEF_N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [N_W-1:0] n_ld_i,
    input  logic [A_W-1:0] a_ld_i,
    output logic           bnd_o,
    output logic           plus_nx_o,
    output logic           mod_o
);

    logic [N_W-1:0] n_q, n_nx;
    logic [A_W-1:0] a_q, a_nx;

    // Next counter values and boundary detection.
    always_comb begin
        bnd_o = tick_i && (n_q == N_W'(1));
        n_nx  = n_q;
        a_nx  = a_q;
        if (bnd_o) begin
            n_nx = n_ld_i;
            a_nx = a_ld_i;
        end else if (tick_i) begin
            n_nx = n_q - N_W'(1);
            a_nx = (a_q != '0) ? a_q - A_W'(1) : a_q;
        end
        plus_nx_o = (a_nx != '0);
        mod_o     = (a_q != '0);
    end

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= N_W'(DEF_N);
            a_q <= '0;
        end else begin
            n_q <= n_nx;
            a_q <= a_nx;
        end
    end

    // Swallow count stays below the main count, so A < N prescaler periods swallow.
    p_swallow_below_main_r1: assert property (@(posedge clk) disable iff (!rst_n)
        N_W'(a_q) < n_q);

    // The modulus request drops only at a prescaler period edge.
    p_mod_drop_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_o) |-> $past(tick_i));

endmodule

// File: rtl/pswal_divider.sv
`timescale 1ns/1ps
// Module: pswal_divider (top)
// Pulse-swallow divider with its behavioural prescaler model. It divides
// clk by M*N + A, drives the modulus request and emits a one-clock
// comparison pulse per output cycle. Settings are checked and applied at
// the boundary. Assumes BASE_MOD >= 2 and N_W >= A_W.
module pswal_divider
    import pswal_pkg::*;
#(
    parameter int unsigned BASE_MOD = 16,
    parameter int unsigned N_W      = PS_N_BITS,
    parameter int unsigned A_W      = PS_A_BITS,
    parameter int unsigned DEF_N    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    input  logic           cfg_sw,
    output logic           mod_ctrl,
    output logic           cmp_pulse,
    output logic           cfg_err
);

    logic [N_W-1:0] n_nx;
    logic [A_W-1:0] a_nx;
    logic           sw_nx, bnd, tick, plus_nx, pulse_q;

    pswal_cfg #(.N_W(N_W), .A_W(A_W), .DEF_N(DEF_N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .n_i(cfg_n), .a_i(cfg_a),
        .sw_i(cfg_sw), .bnd_i(bnd), .n_nx_o(n_nx), .a_nx_o(a_nx),
        .sw_nx_o(sw_nx), .err_o(cfg_err)
    );

    pswal_prescaler #(.BASE(BASE_MOD)) u_pre (
        .clk(clk), .rst_n(rst_n), .sw_i(sw_nx), .plus_i(plus_nx), .tick_o(tick)
    );

    pswal_counters #(.N_W(N_W), .A_W(A_W), .DEF_N(DEF_N)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .n_ld_i(n_nx), .a_ld_i(a_nx),
        .bnd_o(bnd), .plus_nx_o(plus_nx), .mod_o(mod_ctrl)
    );

    // Registered comparison pulse, high for the first clock of each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= bnd;
    end

    assign cmp_pulse = pulse_q;

    // Comparison pulse lasts one clock.
    p_one_clock_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |=> !cmp_pulse);

    // An error flag never follows a cycle without a write.
    p_err_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> !cfg_err);

endmodule

// File: tb/test_pswal_divider.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected periods and modulus-request
// counts; the monitor measures each output cycle and compares.
module test_pswal_divider;

    localparam int BASE  = 4;
    localparam int DEF_N = 8;

    logic        clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0, cfg_sw = 1'b0;
    logic [10:0] cfg_n = '0;
    logic [6:0]  cfg_a = '0;
    logic        mod_ctrl, cmp_pulse, cfg_err;

    always #10 clk = ~clk;

    pswal_divider #(.BASE_MOD(BASE), .DEF_N(DEF_N)) i_pswal_divider (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_n(cfg_n), .cfg_a(cfg_a),
        .cfg_sw(cfg_sw), .mod_ctrl(mod_ctrl), .cmp_pulse(cmp_pulse), .cfg_err(cfg_err)
    );

    typedef struct { int per; int mc; string tag; } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0, pulses = 0, clk_cnt = 0, mc_cnt = 0;
    int cur_per = BASE * DEF_N, cur_mc = 0;
    bit prev_pulse = 0, armed = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: measure each cycle and compare against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            clk_cnt++;
            if (cmp_pulse) begin
                chk(!prev_pulse, "R3", "pulse width", 2, 1);
                if (armed && sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(clk_cnt == e.per, e.tag, "period", clk_cnt, e.per);
                    chk(mc_cnt == e.mc, "R2", "mod_ctrl clocks", mc_cnt, e.mc);
                end
                armed   = 1;
                clk_cnt = 0;
                mc_cnt  = int'(mod_ctrl);
                pulses++;
            end else begin
                mc_cnt += int'(mod_ctrl);
            end
            prev_pulse = cmp_pulse;
        end
    end

    function automatic int per_of(input int n, input int a, input bit sw);
        return (sw ? BASE : 2 * BASE) * n + a;
    endfunction

    function automatic int mc_of(input int a, input bit sw);
        return a * ((sw ? BASE : 2 * BASE) + 1);
    endfunction

    task automatic wait_pulses(input int k);
        int p;
        p = pulses;
        wait (pulses == p + k);
    endtask

    // Offer one setting right after a pulse; queue old then expected new.
    task automatic apply(input int n, input int a, input bit sw,
                         input bit legal, input string tag);
        cfg_n = 11'(n); cfg_a = 7'(a); cfg_sw = sw; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(cfg_err == !legal, "R4", "error flag", int'(cfg_err), int'(!legal));
        sb.push_back('{cur_per, cur_mc, "R5"});
        if (legal) begin
            cur_per = per_of(n, a, sw);
            cur_mc  = mc_of(a, sw);
        end
        sb.push_back('{cur_per, cur_mc, tag});
        wait_pulses(2);
    endtask

    // Two writes on consecutive clocks within one cycle (R6).
    task automatic apply_two(input int n1, input int a1, input bit s1, input bit l1,
                             input int n2, input int a2, input bit s2, input bit l2);
        cfg_n = 11'(n1); cfg_a = 7'(a1); cfg_sw = s1; cfg_wr = 1'b1;
        @(negedge clk);
        chk(cfg_err == !l1, "R6", "first error flag", int'(cfg_err), int'(!l1));
        cfg_n = 11'(n2); cfg_a = 7'(a2); cfg_sw = s2;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(cfg_err == !l2, "R6", "second error flag", int'(cfg_err), int'(!l2));
        sb.push_back('{cur_per, cur_mc, "R5"});
        if (l2) begin
            cur_per = per_of(n2, a2, s2); cur_mc = mc_of(a2, s2);
        end else if (l1) begin
            cur_per = per_of(n1, a1, s1); cur_mc = mc_of(a1, s1);
        end
        sb.push_back('{cur_per, cur_mc, "R6"});
        wait_pulses(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmp_pulse == 1'b0, "R7", "pulse in reset", int'(cmp_pulse), 0);
        chk(cfg_err == 1'b0, "R7", "error in reset", int'(cfg_err), 0);
        chk(mod_ctrl == 1'b0, "R7", "mod_ctrl in reset", int'(mod_ctrl), 0);
        rst_n = 1'b1;
        wait_pulses(1);
        sb.push_back('{BASE * DEF_N, 0, "R7"});
        wait_pulses(1);
        apply(5, 4, 1'b1, 1'b1, "R8");
        apply(100, 37, 1'b0, 1'b1, "R1");
        apply(20, 0, 1'b0, 1'b1, "R2");
        apply(4, 0, 1'b1, 1'b0, "R4");
        apply(9, 9, 1'b1, 1'b0, "R4");
        apply_two(12, 3, 1'b1, 1'b1, 30, 11, 1'b0, 1'b1);
        apply_two(50, 6, 1'b1, 1'b1, 6, 7, 1'b0, 1'b0);
        apply(2047, 127, 1'b0, 1'b1, "R8");
        apply(2047, 0, 1'b1, 1'b1, "R1");
        apply(6, 5, 1'b0, 1'b1, "R1");
        chk(sb.size() == 0, "R1", "queue drained", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #3800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual %0d pulses expected completion", pulses);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule